// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel NOR flash bus. It watches host write cycles made of an 18-bit address and an 8-bit data byte, and recognises command sequences that must begin with a fixed two-write unlock prefix. From these it produces mode levels and single-cycle requests for the memory-array model or controller: read-array mode, identification mode, byte program with its address and data, whole-chip erase, erase of one sector with its index, and suspend and resume of a running sector erase.

Chip-enable and write-enable are active low and asynchronous to the system clock. Both pass through a two-stage synchroniser, and the decoder then detects edges of their combined write strobe. The address of a write cycle is captured when the strobe opens, which is the later of the two enables going low. The data byte is taken when the strobe closes, which is the earlier of the two going high. The host must hold data for at least three system clocks after the strobe closes. The array side reports activity through a busy input. While busy is high, writes are dropped, except the suspend and resume writes of a sector erase.

In identification mode the block returns, combinationally from the address bus, a manufacturer code, a device code or a sector's protect flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_read is 1, mode_id is 0, id_data is 00h and no request pulses.
- R2: A command is decoded only after an unlock prefix: first AAh written to 555h, then 55h written to AAAh. Only address bits 11:0 are compared, so the upper address bits have no effect on the prefix.
- R3: The third write must go to 555h. Data 90h enters identification mode (mode_id = 1). Data A0h arms a byte program, and data 80h arms an erase. Data F0h returns to read mode.
- R4: After A0h, the next write of any address and data produces exactly one prog_req pulse. prog_addr and prog_data then carry that write's address and data, and the decoder returns to read mode.
- R5: After 80h, a second AAh/555h and 55h/AAAh prefix must follow. A sixth write of 10h to 555h pulses chip_erase_req once.
- R6: At that sixth step, 30h written to any address pulses sector_erase_req once. sector_idx then equals address bits 17:13 of that write, and mode_read is 0 while the erase runs.
- R7: A write of F0h at any address leaves identification mode, and it leaves any unlock or setup step other than the program-data step.
- R8: In identification mode, id_data depends on address bits 7:0. Offset 00h gives MFR_ID (default 1Ch), and offset 01h gives DEV_ID (default 92h). Offset 02h gives 0000000b followed by sect_prot[address bits 17:13]. Any other offset gives 00h. Outside identification mode, id_data is 00h.
- R9: While a sector erase runs, B0h at any address pulses suspend_req and mode_read becomes 1. While suspended, 30h at any address pulses resume_req. In these two states, all other writes are ignored.
- R10: While busy is high outside a running or suspended sector erase, every write is ignored. No request is issued and the mode does not change.
- R11: A write that does not match the expected step of a sequence returns the decoder to read mode without any request.
- R12: Every request is a pulse exactly one clock long, and at most one request is high in any cycle.
- R13: The address of a write is the value present when the write strobe opens, and the data is the value present when it closes.
- R14: A running sector erase ends, and read mode returns, on a falling edge of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| addr | input | 18 | Bus address |
| din | input | 8 | Bus write data |
| busy | input | 1 | Array operation in progress |
| sect_prot | input | 32 | Protect flag per sector |
| mode_read | output | 1 | Array reads are valid |
| mode_id | output | 1 | Identification mode active |
| id_data | output | 8 | Identification read data |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | 18 | Byte program address |
| prog_data | output | 8 | Byte program data |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sector_erase_req | output | 1 | Sector erase request pulse |
| sector_idx | output | 5 | Sector to erase |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |

## Verification
A wrong sequence state shows at the ports within one decoded write. A missing or extra request pulse appears, mode_id or mode_read holds the wrong level, or id_data returns a code in the wrong mode. Decoding finishes three clocks after the write strobe closes, so every check samples a few clocks after each write. The programs use deliberately broken prefixes, busy-masked sequences and mid-cycle address changes, so that a state that fails to abort or fails to latch shows up as an extra request count or a wrong captured address.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          AW     = 18,
  parameter int          SW     = 5,
  parameter logic [7:0]  MFR_ID = 8'h1C,
  parameter logic [7:0]  DEV_ID = 8'h92
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        din,
  input  logic              busy,
  input  logic [(1<<SW)-1:0] sect_prot,
  output logic              mode_read,
  output logic              mode_id,
  output logic [7:0]        id_data,
  output logic              prog_req,
  output logic [AW-1:0]     prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_erase_req,
  output logic              sector_erase_req,
  output logic [SW-1:0]     sector_idx,
  output logic              suspend_req,
  output logic              resume_req
);

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_ID, S_PSET, S_ESET, S_E1, S_E2, S_SERA, S_SUSP
  } st_t;

  st_t st, nst;
  logic [1:0] ce_sy, we_sy;
  logic act_q, busy_q;
  logic [AW-1:0] a_lat;
  logic g_prog, g_chip, g_sect, g_susp, g_res;

  wire act     = ~ce_sy[1] & ~we_sy[1];
  wire start   = act & ~act_q;
  wire fin     = ~act & act_q;
  wire hit555  = a_lat[11:0] == 12'h555;
  wire hitAAA  = a_lat[11:0] == 12'hAAA;
  wire in_era  = (st == S_SERA) || (st == S_SUSP);
  wire exec    = fin && (!busy || in_era);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_sy <= 2'b11; we_sy <= 2'b11; act_q <= 1'b0; busy_q <= 1'b0;
      a_lat <= '0;
    end else begin
      ce_sy  <= {ce_sy[0], ce_n};
      we_sy  <= {we_sy[0], we_n};
      act_q  <= act;
      busy_q <= busy;
      if (start) a_lat <= addr;
    end

  always_comb begin
    nst = st;
    g_prog = 1'b0; g_chip = 1'b0; g_sect = 1'b0; g_susp = 1'b0; g_res = 1'b0;
    if (exec)
      case (st)
        S_IDLE: if (hit555 && din == 8'hAA) nst = S_U1;
        S_U1:   nst = (hitAAA && din == 8'h55) ? S_U2 : S_IDLE;
        S_U2: begin
          nst = S_IDLE;
          if (hit555)
            case (din)
              8'h90:   nst = S_ID;
              8'hA0:   nst = S_PSET;
              8'h80:   nst = S_ESET;
              default: nst = S_IDLE;
            endcase
        end
        S_ID:   if (din == 8'hF0) nst = S_IDLE;
        S_PSET: begin nst = S_IDLE; g_prog = 1'b1; end
        S_ESET: nst = (hit555 && din == 8'hAA) ? S_E1 : S_IDLE;
        S_E1:   nst = (hitAAA && din == 8'h55) ? S_E2 : S_IDLE;
        S_E2: begin
          nst = S_IDLE;
          if (hit555 && din == 8'h10) g_chip = 1'b1;
          else if (din == 8'h30) begin g_sect = 1'b1; nst = S_SERA; end
        end
        S_SERA: if (din == 8'hB0) begin g_susp = 1'b1; nst = S_SUSP; end
        S_SUSP: if (din == 8'h30) begin g_res = 1'b1; nst = S_SERA; end
        default: nst = S_IDLE;
      endcase
    if (st == S_SERA && nst == S_SERA && busy_q && !busy) nst = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      prog_req <= 1'b0; chip_erase_req <= 1'b0; sector_erase_req <= 1'b0;
      suspend_req <= 1'b0; resume_req <= 1'b0;
      prog_addr <= '0; prog_data <= '0; sector_idx <= '0;
    end else begin
      st <= nst;
      prog_req <= g_prog; chip_erase_req <= g_chip; sector_erase_req <= g_sect;
      suspend_req <= g_susp; resume_req <= g_res;
      if (g_prog) begin prog_addr <= a_lat; prog_data <= din; end
      if (g_sect) sector_idx <= a_lat[AW-1 -: SW];
    end

  wire [7:0] off = addr[7:0];
  assign mode_id   = st == S_ID;
  assign mode_read = !mode_id && st != S_SERA;
  assign id_data   = !mode_id      ? 8'h00 :
                     off == 8'h00  ? MFR_ID :
                     off == 8'h01  ? DEV_ID :
                     off == 8'h02  ? {7'b0, sect_prot[addr[AW-1 -: SW]]} : 8'h00;

  // R12
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sector_erase_req, suspend_req, resume_req}));
  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fin && !in_era) |=> (st == $past(st)) && !prog_req && !chip_erase_req);
  // R4
  prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(st) == S_PSET);
  // R6
  sect_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erase_req |-> st == S_SERA);
  // R9
  susp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> st == S_SUSP);
  // R9
  res_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> st == S_SERA);

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, busy = 0;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [31:0] sect_prot = 32'h0000_0004;
  logic mode_read, mode_id, prog_req, chip_erase_req, sector_erase_req, suspend_req, resume_req;
  logic [7:0] id_data, prog_data;
  logic [17:0] prog_addr;
  logic [4:0] sector_idx;

  int checks = 0, errors = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_res = 0, n_multi = 0;
  logic [17:0] lp_addr; logic [7:0] lp_data; logic [4:0] ls_idx;
  bit done = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (.*);

  always @(posedge clk) begin
    if (prog_req) begin n_prog++; lp_addr = prog_addr; lp_data = prog_data; end
    if (chip_erase_req) n_chip++;
    if (sector_erase_req) begin n_sect++; ls_idx = sector_idx; end
    if (suspend_req) n_susp++;
    if (resume_req) n_res++;
    if ((prog_req + chip_erase_req + sector_erase_req + suspend_req + resume_req) > 1) n_multi++;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [17:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    repeat (4) @(negedge clk);
    we_n = 1; ce_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock();
    wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h55);
  endtask

  task automatic t_reset();
    chk("R1 mode_read", mode_read, 1);
    chk("R1 mode_id", mode_id, 0);
    chk("R1 id_data", id_data, 0);
    chk("R1 no requests", n_prog + n_chip + n_sect + n_susp + n_res, 0);
  endtask

  task automatic t_autoselect();
    unlock(); wr(18'h00555, 8'h90);
    chk("R3 autoselect entered", mode_id, 1);
    chk("R3 mode_read low", mode_read, 0);
    addr = 18'h00000; #1 chk("R8 manufacturer", id_data, 8'h1C);
    addr = 18'h00001; #1 chk("R8 device", id_data, 8'h92);
    addr = {5'd2, 13'h0002}; #1 chk("R8 protected sector", id_data, 8'h01);
    addr = {5'd3, 13'h0002}; #1 chk("R8 unprotected sector", id_data, 8'h00);
    addr = 18'h00003; #1 chk("R8 other offset", id_data, 8'h00);
    wr(18'h00555, 8'hAA);
    chk("R7 non-F0 write stays in autoselect", mode_id, 1);
    wr(18'h31234, 8'hF0);
    chk("R7 F0 exits autoselect", mode_id, 0);
    addr = 18'h00000; #1 chk("R8 id_data zero outside autoselect", id_data, 0);
  endtask

  task automatic t_program();
    wr(18'h3F555, 8'hAA); wr(18'h10AAA, 8'h55); wr(18'h2A555, 8'hA0);
    wr(18'h2ABCD, 8'h5A);
    chk("R2 upper bits ignored, R4 one request", n_prog, 1);
    chk("R4 prog_addr", lp_addr, 18'h2ABCD);
    chk("R4 prog_data", lp_data, 8'h5A);
    chk("R4 back to read", mode_read, 1);
  endtask

  task automatic t_latch();
    unlock(); wr(18'h00555, 8'hA0);
    @(negedge clk); addr = 18'h12345; din = 8'h00; ce_n = 0; we_n = 0;
    repeat (4) @(negedge clk);
    addr = 18'h3FFFF; din = 8'h3C;
    repeat (3) @(negedge clk);
    we_n = 1; ce_n = 1;
    repeat (4) @(negedge clk);
    chk("R13 program count", n_prog, 2);
    chk("R13 address from strobe open", lp_addr, 18'h12345);
    chk("R13 data from strobe close", lp_data, 8'h3C);
  endtask

  task automatic t_chip();
    unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h00555, 8'h10);
    chk("R5 chip erase", n_chip, 1);
    chk("R5 no program", n_prog, 2);
  endtask

  task automatic t_sector();
    unlock(); wr(18'h00555, 8'h80); unlock(); wr({5'd21, 13'h0777}, 8'h30);
    chk("R6 sector request", n_sect, 1);
    chk("R6 sector index", ls_idx, 21);
    chk("R6 mode_read low while erasing", mode_read, 0);
    busy = 1;
    wr(18'h00040, 8'h30);
    chk("R9 30h ignored while running", n_res, 0);
    wr(18'h00012, 8'hB0);
    chk("R9 suspend", n_susp, 1);
    chk("R9 read allowed when suspended", mode_read, 1);
    busy = 0;
    wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h55); wr(18'h00555, 8'h90);
    chk("R9 writes ignored while suspended", mode_id, 0);
    wr(18'h20001, 8'h30);
    chk("R9 resume", n_res, 1);
    chk("R9 running again", mode_read, 0);
    @(negedge clk); busy = 1; repeat (3) @(negedge clk);
    busy = 0; repeat (4) @(negedge clk);
    chk("R14 busy fall ends erase", mode_read, 1);
    unlock(); wr(18'h00555, 8'h90);
    chk("R14 commands accepted after erase", mode_id, 1);
    wr(18'h00000, 8'hF0);
  endtask

  task automatic t_busy();
    @(negedge clk); busy = 1;
    unlock(); wr(18'h00555, 8'hA0); wr(18'h01000, 8'h77);
    chk("R10 program ignored while busy", n_prog, 2);
    unlock(); wr(18'h00555, 8'h90);
    chk("R10 autoselect ignored while busy", mode_id, 0);
    busy = 0;
    wr(18'h01000, 8'h77);
    chk("R10 no half sequence kept", n_prog, 2);
  endtask

  task automatic t_mismatch();
    unlock(); wr(18'h00554, 8'h90);
    chk("R11 third write wrong address", mode_id, 0);
    wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h54); wr(18'h00555, 8'h90);
    chk("R11 wrong second data", mode_id, 0);
    unlock(); wr(18'h00555, 8'h80); wr(18'h00555, 8'hAA); wr(18'h00AAB, 8'h55);
    wr(18'h00555, 8'h10);
    chk("R11 broken erase prefix", n_chip, 1);
    unlock(); wr(18'h00555, 8'h80); wr(18'h00000, 8'hF0);
    unlock(); wr(18'h00555, 8'h90);
    chk("R7 F0 in erase setup then fresh command", mode_id, 1);
    wr(18'h00000, 8'hF0);
    chk("R12 one pulse per request, never two at once", n_multi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_autoselect();
    t_program();
    t_latch();
    t_chip();
    t_sector();
    t_busy();
    t_mismatch();
    chk("R12 total programs", n_prog, 2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule